// File: doc/BRIEF.md
# Serial EEPROM Slave Model (128 x 16)

This block models a three-wire serial EEPROM that answers on the slave side of the bus. It holds 128 words of 16 bits. The master drives a select line, a serial clock and a serial data input. The block drives a serial data output together with an output-enable, which stands in for the high-impedance state.

All pins are sampled into the system clock domain through a synchroniser. The serial clock must therefore run at a small fraction of the system clock. A frame starts with a 1 bit, followed by a two-bit operation code and an eight-bit address field. Write-type frames then carry sixteen data bits. The block reads words, writes one word, fills every word with one value, and sets or clears a write-enable latch.

A write is held back until select falls after a complete frame. It then runs for a programmable number of system clocks. While that timer runs, raising select shows the busy or ready state on the data output.

The serial pins are plain level signals, not a stream. There is no valid/ready handshake and no back-pressure. The master paces every transfer with its clock edges.

Top module: `seep_slave`

## Requirements
- R1: After reset the output enable is low, every word reads 0x0000, and the write-enable latch is clear. A write frame sent before an enable frame leaves the array unchanged and shows no status.
- R2: A read frame is 1, then 10, then eight address bits, all sampled on rising serial-clock edges. After the 11th rising edge the output is enabled and drives a 0 dummy bit. After edges 12 through 27 it drives bits 15 down to 0 of the addressed word.
- R3: While select stays high after a read, every further rising edge shifts out the next word's bits, MSB first, with no dummy bit between words. The address wraps from 127 to 0.
- R4: Frame 1, 00, 11 followed by six don't-care bits sets the write-enable latch. Frame 1, 00, 00 followed by six don't-care bits clears it. While the latch is clear, write frames are ignored and reads still work.
- R5: A write frame is 1, 01, eight address bits, then 16 data bits MSB first; the last data bit is on edge 27. When select falls, the addressed word is replaced by the new data, with no erase needed beforehand. Address bit 7 is ignored and bits 6..0 select the word.
- R6: Frame 1, 00, 01 followed by six don't-care bits and then 16 data bits stores that value into all 128 words in one timed write period.
- R7: After an accepted write has started, raising select with no frame in progress enables the output. The output is 0 for the BUSY_CYCLES system clocks of the write period and 1 afterwards.
- R8: The output enable is low whenever select is low and while command bits are being shifted in.
- R9: Any frame sent while the write timer runs is ignored.
- R10: If select falls before the 27th edge of a write frame, nothing is written and no status is shown.
- R11: Zero bits clocked in before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 1 | Slave select, active high |
| ser_clk | input | 1 | Serial clock from the master |
| ser_in | input | 1 | Serial command and data input |
| ser_out | output | 1 | Serial read data or busy/ready level |
| ser_out_en | output | 1 | High when ser_out is driven (low = high impedance) |

## Verification
The bench builds the block with BUSY_CYCLES set to 300 and leaves the other parameters at their defaults: 128 words, 16-bit data, an eight-bit address field and a two-stage synchroniser. A 300-cycle write period is longer than a full 11-bit command frame clocked at 16 system clocks per serial bit. This lets the bench place a whole frame inside the busy window to show it is ignored, and still see both the busy and the ready level within a short run. The default word count puts address 127 within reach, so the wrap to word 0 during a sequential read is tested.

// File: rtl/seep_pkg.sv
package seep_pkg;
  typedef enum logic [2:0] {
    FR_IDLE,
    FR_OPC,
    FR_ADR,
    FR_DAT,
    FR_RD,
    FR_END
  } fr_state_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/seep_sync.sv
module seep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_pin,
  input  logic sk_pin,
  input  logic di_pin,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise,
  output logic cs_fall
);
  localparam int NPINS = 3;

  logic [NPINS-1:0]  raw;
  logic [STAGES-1:0] chain [NPINS];
  logic              sk_s, sk_d, cs_d;

  assign raw = {cs_pin, sk_pin, di_pin};

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= {chain[g][STAGES-2:0], raw[g]};
      end
    end
  endgenerate

  assign di_s = chain[0][STAGES-1];
  assign sk_s = chain[1][STAGES-1];
  assign cs_s = chain[2][STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_d <= 1'b0;
      cs_d <= 1'b0;
    end else begin
      sk_d <= sk_s;
      cs_d <= cs_s;
    end
  end

  assign sk_rise = sk_s & ~sk_d;
  assign cs_fall = ~cs_s & cs_d;
endmodule

// File: rtl/seep_frame.sv
module seep_frame
  import seep_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int ADDR_BITS = 8,
  parameter int IDX_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             di_s,
  input  logic             sk_rise,
  input  logic             cs_fall,
  input  logic             busy,
  input  logic [WIDTH-1:0] rd_word,
  output logic [IDX_W-1:0] word_idx,
  output logic             set_wen,
  output logic             clr_wen,
  output logic             wr_req,
  output logic             wr_all,
  output logic [WIDTH-1:0] wr_data,
  output logic             frame_active,
  output logic             sdo,
  output logic             sdo_en
);
  localparam int CNT_MAX = (WIDTH > ADDR_BITS) ? WIDTH : ADDR_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int POS_W   = $clog2(WIDTH);

  fr_state_e            st;
  logic [CNT_W-1:0]     cnt;
  logic [1:0]           opc;
  logic [ADDR_BITS-2:0] adr_sh;
  logic [ADDR_BITS-1:0] adr_next;
  logic [1:0]           sub;
  logic [WIDTH-1:0]     dat_sh;
  logic [POS_W-1:0]     pos;
  logic [IDX_W-1:0]     idx_q;
  logic                 rd_bit, have_wr, fill_q, stat_arm, rd_active;

  assign adr_next = {adr_sh, di_s};
  assign sub      = adr_next[ADDR_BITS-1 -: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FR_IDLE;
      cnt      <= '0;
      opc      <= '0;
      adr_sh   <= '0;
      dat_sh   <= '0;
      pos      <= '0;
      idx_q    <= '0;
      rd_bit   <= 1'b0;
      have_wr  <= 1'b0;
      fill_q   <= 1'b0;
      stat_arm <= 1'b0;
      set_wen  <= 1'b0;
      clr_wen  <= 1'b0;
      wr_req   <= 1'b0;
    end else begin
      set_wen <= 1'b0;
      clr_wen <= 1'b0;
      wr_req  <= 1'b0;
      if (busy) stat_arm <= 1'b1;
      if (cs_fall) begin
        if (st == FR_END && have_wr) wr_req <= 1'b1;
        st      <= FR_IDLE;
        have_wr <= 1'b0;
      end else if (cs_s && sk_rise) begin
        case (st)
          FR_IDLE: begin
            if (!busy && di_s) begin
              st       <= FR_OPC;
              cnt      <= '0;
              stat_arm <= 1'b0;
            end
          end
          FR_OPC: begin
            opc <= {opc[0], di_s};
            if (cnt == CNT_W'(1)) begin
              st  <= FR_ADR;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_ADR: begin
            adr_sh <= adr_next[ADDR_BITS-2:0];
            if (cnt == CNT_W'(ADDR_BITS-1)) begin
              cnt   <= '0;
              idx_q <= adr_next[IDX_W-1:0];
              case (opc)
                OPC_READ: begin
                  st     <= FR_RD;
                  pos    <= POS_W'(WIDTH-1);
                  rd_bit <= 1'b0;
                end
                OPC_WRITE: begin
                  st     <= FR_DAT;
                  fill_q <= 1'b0;
                end
                OPC_EXT: begin
                  case (sub)
                    SUB_FILL: begin
                      st     <= FR_DAT;
                      fill_q <= 1'b1;
                    end
                    SUB_UNLOCK: begin
                      set_wen <= 1'b1;
                      st      <= FR_END;
                    end
                    SUB_LOCK: begin
                      clr_wen <= 1'b1;
                      st      <= FR_END;
                    end
                    default: st <= FR_END;
                  endcase
                end
                default: st <= FR_END;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_DAT: begin
            dat_sh <= {dat_sh[WIDTH-2:0], di_s};
            if (cnt == CNT_W'(WIDTH-1)) begin
              st      <= FR_END;
              have_wr <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_RD: begin
            rd_bit <= rd_word[pos];
            if (pos == '0) begin
              pos   <= POS_W'(WIDTH-1);
              idx_q <= idx_q + 1'b1;
            end else begin
              pos <= pos - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign word_idx     = idx_q;
  assign wr_all       = fill_q;
  assign wr_data      = dat_sh;
  assign frame_active = (st != FR_IDLE);
  assign rd_active    = (st == FR_RD);
  assign sdo          = rd_active ? rd_bit : !busy;
  assign sdo_en       = cs_s && (rd_active || (st == FR_IDLE && stat_arm));

  // R2: the first bit presented by a read is the dummy zero
  assert_dummy_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> (sdo_en && !sdo));

  // R8: output stays released while command bits arrive
  assert_quiet_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_OPC || st == FR_ADR || st == FR_DAT) |-> !sdo_en);
endmodule

// File: rtl/seep_store.sv
module seep_store #(
  parameter int WORDS       = 128,
  parameter int WIDTH       = 16,
  parameter int IDX_W       = 7,
  parameter int BUSY_CYCLES = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_wen,
  input  logic             clr_wen,
  input  logic             wr_req,
  input  logic             wr_all,
  input  logic [IDX_W-1:0] word_idx,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_word,
  output logic             busy
);
  localparam int TMR_W = $clog2(BUSY_CYCLES + 1);

  logic [WIDTH-1:0] mem [WORDS];
  logic [TMR_W-1:0] tmr;
  logic             wen_q, pend_all, commit;
  logic [IDX_W-1:0] pend_idx;
  logic [WIDTH-1:0] pend_data;

  assign rd_word = mem[word_idx];
  assign commit  = busy && (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wen_q <= 1'b0;
    else if (set_wen) wen_q <= 1'b1;
    else if (clr_wen) wen_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tmr       <= '0;
      pend_all  <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
    end else if (busy) begin
      if (tmr == '0) busy <= 1'b0;
      else           tmr  <= tmr - 1'b1;
    end else if (wr_req && wen_q) begin
      busy      <= 1'b1;
      tmr       <= TMR_W'(BUSY_CYCLES - 1);
      pend_all  <= wr_all;
      pend_idx  <= word_idx;
      pend_data <= wr_data;
    end
  end

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[w] <= '0;
        else if (commit && (pend_all || pend_idx == IDX_W'(w)))
          mem[w] <= pend_data;
      end
    end
  endgenerate

  // R4: a timed write only starts with the latch set
  assert_gate_by_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));

  // R6: a fill reaches both ends of the array
  assert_fill_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && pend_all) |=> (mem[0] == $past(pend_data) && mem[WORDS-1] == $past(pend_data)));
endmodule

// File: rtl/seep_slave.sv
module seep_slave #(
  parameter int WORDS       = 128,
  parameter int WIDTH       = 16,
  parameter int ADDR_BITS   = 8,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_out_en
);
  localparam int IDX_W = $clog2(WORDS);

  logic             cs_s, di_s, sk_rise, cs_fall;
  logic             set_wen, clr_wen, wr_req, wr_all, busy, frame_active;
  logic [IDX_W-1:0] word_idx;
  logic [WIDTH-1:0] wr_data, rd_word;

  seep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_pin(chip_sel), .sk_pin(ser_clk), .di_pin(ser_in),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  seep_frame #(.WIDTH(WIDTH), .ADDR_BITS(ADDR_BITS), .IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_fall(cs_fall),
    .busy(busy), .rd_word(rd_word), .word_idx(word_idx),
    .set_wen(set_wen), .clr_wen(clr_wen), .wr_req(wr_req), .wr_all(wr_all),
    .wr_data(wr_data), .frame_active(frame_active),
    .sdo(ser_out), .sdo_en(ser_out_en)
  );

  seep_store #(.WORDS(WORDS), .WIDTH(WIDTH), .IDX_W(IDX_W), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .set_wen(set_wen), .clr_wen(clr_wen), .wr_req(wr_req), .wr_all(wr_all),
    .word_idx(word_idx), .wr_data(wr_data), .rd_word(rd_word), .busy(busy)
  );

  // Independent count of the busy window length
  logic [31:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  // R7: the write period lasts exactly BUSY_CYCLES clocks
  assert_busy_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 32'(BUSY_CYCLES)));

  // R9: no frame is decoded while the timer runs
  assert_idle_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !frame_active);
endmodule

// File: tb/seep_slave_bench.sv
module seep_slave_bench;
  localparam int HALF = 8;
  localparam int BUSY = 300;

  logic clk = 1'b0;
  logic rst_n, chip_sel, ser_clk, ser_in;
  logic ser_out, ser_out_en;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic [15:0] model [128];
  logic [15:0] rd_buf [4];

  always #2 clk = ~clk;

  seep_slave #(.BUSY_CYCLES(BUSY)) u_seep_slave (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .ser_clk(ser_clk),
    .ser_in(ser_in), .ser_out(ser_out), .ser_out_en(ser_out_en)
  );

  // {address, data} write vectors
  localparam logic [23:0] VEC [6] = '{
    24'h00_1234, 24'h7F_A55A, 24'h85_BEEF,
    24'h10_0001, 24'h11_8000, 24'h10_FFFF
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b, output logic o, output logic oe);
    ser_in = b;
    wait_cyc(HALF);
    ser_clk = 1'b1;
    wait_cyc(HALF);
    o  = ser_out;
    oe = ser_out_en;
    ser_clk = 1'b0;
  endtask

  task automatic select();
    chip_sel = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic deselect();
    ser_in = 1'b0;
    wait_cyc(HALF);
    chip_sel = 1'b0;
    wait_cyc(HALF);
  endtask

  // start bit, opcode, address; counts enabled samples on the first 10 edges
  task automatic head(input logic [1:0] op, input logic [7:0] a,
                      output int loud, output logic lo, output logic loe);
    logic o, oe;
    loud = 0;
    pulse(1'b1, o, oe); if (oe) loud++;
    for (int i = 1; i >= 0; i--) begin pulse(op[i], o, oe); if (oe) loud++; end
    for (int i = 7; i >= 1; i--) begin pulse(a[i], o, oe); if (oe) loud++; end
    pulse(a[0], lo, loe);
  endtask

  task automatic data16(input logic [15:0] d);
    logic o, oe;
    for (int i = 15; i >= 0; i--) pulse(d[i], o, oe);
  endtask

  task automatic status(input bit ok, input string req);
    select();
    wait_cyc(6);
    if (ok) begin
      chk({req, " status enabled"}, 32'(ser_out_en), 32'd1);
      chk({req, " R7 busy level"}, 32'(ser_out), 32'd0);
      wait_cyc(BUSY + 50);
      chk({req, " R7 ready level"}, 32'(ser_out), 32'd1);
    end else begin
      chk({req, " no status"}, 32'(ser_out_en), 32'd0);
    end
    deselect();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input bit ok, input string req);
    int loud; logic o, oe;
    select();
    head(2'b01, a, loud, o, oe);
    data16(d);
    deselect();
    status(ok, req);
    if (ok) model[a[6:0]] = d;
  endtask

  task automatic do_ext(input logic [1:0] sub);
    int loud; logic o, oe;
    select();
    head(2'b00, {sub, 6'b0}, loud, o, oe);
    deselect();
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input string req);
    int loud; logic o, oe;
    select();
    head(2'b10, a, loud, o, oe);
    chk({req, " R8 quiet during command"}, 32'(loud), 32'd0);
    chk({req, " R2 dummy bit"}, {30'd0, oe, o}, 32'd2);
    for (int k = 0; k < n; k++)
      for (int b = 15; b >= 0; b--) begin
        pulse(1'b0, o, oe);
        rd_buf[k][b] = o;
      end
    deselect();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic o, oe;
    int loud;
    for (int i = 0; i < 128; i++) model[i] = 16'h0000;
    rst_n = 1'b0; chip_sel = 1'b0; ser_clk = 1'b0; ser_in = 1'b0;
    wait_cyc(10);
    chk("R1 output released in reset", 32'(ser_out_en), 32'd0);
    rst_n = 1'b1;
    wait_cyc(5);

    // R1: write before enable is rejected
    do_write(8'h05, 16'hBEEF, 1'b0, "R1 locked write");
    do_read(8'h05, 1, "R1");
    chk("R1 word unchanged", 32'(rd_buf[0]), 32'h0);

    // R4: enable, then walk the vector table (R5)
    do_ext(2'b11);
    for (int i = 0; i < 6; i++) begin
      do_write(VEC[i][23:16], VEC[i][15:0], 1'b1, "R5 write");
      do_read(VEC[i][23:16], 1, "R5");
      chk("R5 readback", 32'(rd_buf[0]), 32'(model[VEC[i][22:16]]));
    end
    do_read(8'h05, 1, "R5 A7 ignored");
    chk("R5 A7 don't-care lands on word 5", 32'(rd_buf[0]), 32'hBEEF);

    // R3: sequential read and wrap
    do_read(8'h10, 3, "R3");
    chk("R3 word 16", 32'(rd_buf[0]), 32'(model[16]));
    chk("R3 word 17", 32'(rd_buf[1]), 32'(model[17]));
    chk("R3 word 18", 32'(rd_buf[2]), 32'(model[18]));
    do_read(8'h7F, 2, "R3 wrap");
    chk("R3 word 127", 32'(rd_buf[0]), 32'(model[127]));
    chk("R3 wrap to word 0", 32'(rd_buf[1]), 32'(model[0]));

    // R9: a disable frame sent during busy is ignored
    select();
    head(2'b01, 8'h20, loud, o, oe);
    data16(16'h1111);
    deselect();
    select();
    wait_cyc(6);
    chk("R9 busy before frame", 32'(ser_out), 32'd0);
    head(2'b00, 8'h00, loud, o, oe);
    deselect();
    wait_cyc(BUSY + 50);
    model[8'h20] = 16'h1111;
    do_write(8'h21, 16'h2222, 1'b1, "R9 still enabled");
    do_read(8'h20, 2, "R9");
    chk("R9 word 0x20", 32'(rd_buf[0]), 32'h1111);
    chk("R9 word 0x21", 32'(rd_buf[1]), 32'h2222);

    // R10: truncated write
    select();
    head(2'b01, 8'h30, loud, o, oe);
    for (int i = 0; i < 10; i++) pulse(1'b1, o, oe);
    deselect();
    status(1'b0, "R10 truncated");
    do_read(8'h30, 1, "R10");
    chk("R10 word untouched", 32'(rd_buf[0]), 32'(model[8'h30]));

    // R11: leading zeros before start bit
    select();
    for (int i = 0; i < 3; i++) pulse(1'b0, o, oe);
    head(2'b10, 8'h00, loud, o, oe);
    chk("R11 dummy after zeros", {30'd0, oe, o}, 32'd2);
    for (int b = 15; b >= 0; b--) begin
      pulse(1'b0, o, oe);
      rd_buf[0][b] = o;
    end
    deselect();
    chk("R11 read after leading zeros", 32'(rd_buf[0]), 32'(model[0]));
    chk("R8 released after deselect", 32'(ser_out_en), 32'd0);

    // R6: fill all words
    select();
    head(2'b00, 8'b0100_0000, loud, o, oe);
    data16(16'h5A5A);
    deselect();
    status(1'b1, "R6 fill");
    for (int i = 0; i < 128; i++) model[i] = 16'h5A5A;
    do_read(8'h00, 1, "R6");
    chk("R6 word 0", 32'(rd_buf[0]), 32'h5A5A);
    do_read(8'h40, 1, "R6");
    chk("R6 word 64", 32'(rd_buf[0]), 32'h5A5A);
    do_read(8'h7F, 1, "R6");
    chk("R6 word 127", 32'(rd_buf[0]), 32'h5A5A);

    // R4: disable blocks writes, reads still work
    do_ext(2'b00);
    do_write(8'h40, 16'h1234, 1'b0, "R4 locked");
    do_read(8'h40, 1, "R4");
    chk("R4 word kept after lock", 32'(rd_buf[0]), 32'h5A5A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule